// File: doc/BRIEF.md
# Transmit Descriptor Ring Scheduler

This block holds the per-channel transmit state of a cell segmentation engine. Every transmit channel has a circular ring of descriptors in a local descriptor store and a head pointer that names the oldest queued entry. When a cell slot comes up, the rate logic presents a channel number. One cycle later the block answers with one of two results. It either issues the buffer handle found at that channel's head, or it signals that an idle cell must go out in that slot.

A host-side port writes descriptors, retires them and turns channels on or off, so that software can apply back-pressure. A completion strobe from the segmentation engine says that the buffer now being served is finished. The block then clears that descriptor's queued bit and moves the head on by one. This gives strict first-in, first-out service within each ring. Channel number zero is never usable and always answers with an idle cell. `CH_W` sets the channel count: a width of 8 gives 255 usable channels, and the small default keeps the descriptor store to 2048 entries. `RING_W` sets the ring depth, which is 256 entries by default.

Top module: `tx_ring_sched`

## Requirements
- R1: After reset every head pointer is 0, every channel is disabled and every descriptor is empty, so any slot request yields an idle cell. The outputs stay low until the first slot is answered.
- R2: Channel 0 always yields an idle cell. Host operations and completions addressed to channel 0 change nothing.
- R3: A slot request in cycle t produces exactly one of `cell_issue` or `cell_idle` in cycle t+1. `cell_ch` echoes the requested channel. Without a request, both strobes stay low.
- R4: A channel whose enable bit is clear yields an idle cell, whatever its descriptors hold.
- R5: For an enabled channel whose head entry is queued, `cell_issue` is raised, `cell_entry` carries the head index and `cell_handle` carries the stored handle. On an idle cell, `cell_entry` and `cell_handle` are 0.
- R6: For an enabled channel whose head entry is empty, the result is an idle cell, and nothing stalls.
- R7: A completion on channel c clears the queued bit of the entry at c's head and advances the head by one, wrapping from 255 to 0.
- R8: The buffers of one channel are issued in ring order, one buffer at a time. The head moves only on completion.
- R9: When a host entry write and a slot read hit the same entry in the same cycle, the slot sees the newly written value.
- R10: Host opcode 2 (retire) clears the queued bit of entry (`host_ch`, `host_idx`) and leaves the head pointer where it is.
- R11: The host opcodes are 0 (write descriptor: queued bit from `host_active`, handle from `host_handle`), 1 (set channel enable to `host_active`), 2 (retire) and 3 (no effect).
- R12: When a completion and a host descriptor write hit the same entry in the same cycle, the host value is what remains stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | A cell slot asks for a channel decision |
| slot_ch | input | CH_W | Channel chosen for the slot |
| done_valid | input | 1 | Buffer at a channel's head has been fully sent |
| done_ch | input | CH_W | Channel whose buffer completed |
| host_we | input | 1 | Host operation strobe |
| host_op | input | 2 | Host opcode (see R11) |
| host_ch | input | CH_W | Channel addressed by the host |
| host_idx | input | RING_W | Ring entry addressed by the host |
| host_active | input | 1 | Queued bit for opcode 0, enable value for opcode 1 |
| host_handle | input | HANDLE_W | Buffer handle for opcode 0 |
| cell_issue | output | 1 | Slot carries a buffer |
| cell_idle | output | 1 | Slot carries an idle cell |
| cell_ch | output | CH_W | Channel the result belongs to |
| cell_entry | output | RING_W | Ring index of the issued buffer |
| cell_handle | output | HANDLE_W | Handle of the issued buffer |

## Verification
The hardest case to reach is the head wrap combined with the completion-versus-host-write collision on one entry. Seeing the result means walking a ring through all 256 completions and then arriving back at the contested entry. The bench drives a completion and a descriptor write to entry 0 of one channel in the same cycle. It then issues 254 further completions, checks the issue at index 255, completes once more and expects the host-written handle at index 0. The same-cycle host write and slot read is driven directly, in both write and retire forms.

// File: rtl/txr_pkg.sv
package txr_pkg;

    typedef enum logic [1:0] {
        HOP_DESC   = 2'd0,
        HOP_ENABLE = 2'd1,
        HOP_RETIRE = 2'd2,
        HOP_NOP    = 2'd3
    } host_op_e;

endpackage

// File: rtl/txr_head_table.sv
module txr_head_table #(
    parameter int CH_W   = 3,
    parameter int RING_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_valid,
    input  logic [CH_W-1:0]   adv_ch,
    input  logic              en_we,
    input  logic [CH_W-1:0]   en_ch,
    input  logic              en_val,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [RING_W-1:0] rd_head,
    output logic              rd_en,
    output logic [RING_W-1:0] adv_head
);
    localparam int NCH = 1 << CH_W;

    typedef struct packed {
        logic [NCH-1:0][RING_W-1:0] head;
        logic [NCH-1:0]             en;
    } ht_t;

    ht_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_valid) begin
            st_d.head[adv_ch] = st_q.head[adv_ch] + RING_W'(1);
        end
        if (en_we) begin
            st_d.en[en_ch] = en_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_head  = st_q.head[rd_ch];
    assign rd_en    = st_q.en[rd_ch];
    assign adv_head = st_q.head[adv_ch];

    // R7: a completion moves that channel's head forward by exactly one
    p_head_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adv_valid |=> st_q.head[$past(adv_ch)] == $past(st_q.head[adv_ch]) + RING_W'(1));

    // R8 / R10: without a completion no head pointer moves
    p_head_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_valid |=> $stable(st_q.head));

endmodule

// File: rtl/txr_desc_mem.sv
module txr_desc_mem #(
    parameter int CH_W     = 3,
    parameter int RING_W   = 8,
    parameter int HANDLE_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_valid,
    input  logic [CH_W+RING_W-1:0] clr_addr,
    input  logic                   wr_valid,
    input  logic [CH_W+RING_W-1:0] wr_addr,
    input  logic                   wr_active,
    input  logic                   wr_handle_en,
    input  logic [HANDLE_W-1:0]    wr_handle,
    input  logic [CH_W+RING_W-1:0] rd_addr,
    output logic                   rd_active,
    output logic [HANDLE_W-1:0]    rd_handle
);
    localparam int ADDR_W = CH_W + RING_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0] act;
    } dm_t;

    dm_t st_d, st_q;
    logic [HANDLE_W-1:0] handle_mem [DEPTH];
    logic rd_hit;

    always_comb begin
        st_d = st_q;
        if (clr_valid) st_d.act[clr_addr] = 1'b0;
        if (wr_valid)  st_d.act[wr_addr]  = wr_active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_handle_en) handle_mem[wr_addr] <= wr_handle;
    end

    assign rd_hit    = wr_valid && (wr_addr == rd_addr);
    assign rd_active = rd_hit ? wr_active : st_q.act[rd_addr];
    assign rd_handle = (rd_hit && wr_handle_en) ? wr_handle : handle_mem[rd_addr];

    // R7: a completed entry is empty afterwards unless the host rewrote it
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !(wr_valid && wr_addr == clr_addr)) |=> !st_q.act[$past(clr_addr)]);

    // R12: a host entry write always lands, even against a same-cycle clear
    p_host_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> st_q.act[$past(wr_addr)] == $past(wr_active));

endmodule

// File: rtl/txr_cell_out.sv
module txr_cell_out #(
    parameter int CH_W     = 3,
    parameter int RING_W   = 8,
    parameter int HANDLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot_valid,
    input  logic [CH_W-1:0]     slot_ch,
    input  logic                ch_en,
    input  logic [RING_W-1:0]   head,
    input  logic                active,
    input  logic [HANDLE_W-1:0] handle,
    output logic                cell_issue,
    output logic                cell_idle,
    output logic [CH_W-1:0]     cell_ch,
    output logic [RING_W-1:0]   cell_entry,
    output logic [HANDLE_W-1:0] cell_handle
);
    typedef struct packed {
        logic                issue;
        logic                idle;
        logic [CH_W-1:0]     ch;
        logic [RING_W-1:0]   entry;
        logic [HANDLE_W-1:0] handle;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d = '0;
        if (slot_valid) begin
            o_d.ch = slot_ch;
            if ((slot_ch != '0) && ch_en && active) begin
                o_d.issue  = 1'b1;
                o_d.entry  = head;
                o_d.handle = handle;
            end else begin
                o_d.idle = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign cell_issue  = o_q.issue;
    assign cell_idle   = o_q.idle;
    assign cell_ch     = o_q.ch;
    assign cell_entry  = o_q.entry;
    assign cell_handle = o_q.handle;

    // R3: one result per slot, none without a slot
    p_one_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |=> (cell_issue ^ cell_idle));
    p_no_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_valid |=> !cell_issue && !cell_idle);

    // R2: channel zero never issues
    p_null_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_ch == '0) |=> cell_idle);

    // R4: a disabled channel never issues
    p_disabled_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && !ch_en) |=> cell_idle);

endmodule

// File: rtl/tx_ring_sched.sv
module tx_ring_sched
    import txr_pkg::*;
#(
    parameter int CH_W     = 3,
    parameter int RING_W   = 8,
    parameter int HANDLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot_valid,
    input  logic [CH_W-1:0]     slot_ch,
    input  logic                done_valid,
    input  logic [CH_W-1:0]     done_ch,
    input  logic                host_we,
    input  logic [1:0]          host_op,
    input  logic [CH_W-1:0]     host_ch,
    input  logic [RING_W-1:0]   host_idx,
    input  logic                host_active,
    input  logic [HANDLE_W-1:0] host_handle,
    output logic                cell_issue,
    output logic                cell_idle,
    output logic [CH_W-1:0]     cell_ch,
    output logic [RING_W-1:0]   cell_entry,
    output logic [HANDLE_W-1:0] cell_handle
);
    localparam int ADDR_W = CH_W + RING_W;

    host_op_e            op;
    logic                host_ok, en_we, ent_we, ent_active, ent_handle_en, adv;
    logic [RING_W-1:0]   rd_head, adv_head;
    logic                rd_en, rd_active;
    logic [HANDLE_W-1:0] rd_handle;
    logic [ADDR_W-1:0]   clr_addr, wr_addr, rd_addr;

    assign op            = host_op_e'(host_op);
    assign host_ok       = host_we && (host_ch != '0);
    assign en_we         = host_ok && (op == HOP_ENABLE);
    assign ent_we        = host_ok && ((op == HOP_DESC) || (op == HOP_RETIRE));
    assign ent_active    = (op == HOP_DESC) ? host_active : 1'b0;
    assign ent_handle_en = host_ok && (op == HOP_DESC);
    assign adv           = done_valid && (done_ch != '0);

    assign clr_addr = {done_ch, adv_head};
    assign wr_addr  = {host_ch, host_idx};
    assign rd_addr  = {slot_ch, rd_head};

    txr_head_table #(.CH_W(CH_W), .RING_W(RING_W)) u_heads (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_valid(adv),
        .adv_ch   (done_ch),
        .en_we    (en_we),
        .en_ch    (host_ch),
        .en_val   (host_active),
        .rd_ch    (slot_ch),
        .rd_head  (rd_head),
        .rd_en    (rd_en),
        .adv_head (adv_head)
    );

    txr_desc_mem #(.CH_W(CH_W), .RING_W(RING_W), .HANDLE_W(HANDLE_W)) u_desc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_valid   (adv),
        .clr_addr    (clr_addr),
        .wr_valid    (ent_we),
        .wr_addr     (wr_addr),
        .wr_active   (ent_active),
        .wr_handle_en(ent_handle_en),
        .wr_handle   (host_handle),
        .rd_addr     (rd_addr),
        .rd_active   (rd_active),
        .rd_handle   (rd_handle)
    );

    txr_cell_out #(.CH_W(CH_W), .RING_W(RING_W), .HANDLE_W(HANDLE_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_valid (slot_valid),
        .slot_ch    (slot_ch),
        .ch_en      (rd_en),
        .head       (rd_head),
        .active     (rd_active),
        .handle     (rd_handle),
        .cell_issue (cell_issue),
        .cell_idle  (cell_idle),
        .cell_ch    (cell_ch),
        .cell_entry (cell_entry),
        .cell_handle(cell_handle)
    );

    // R2: host traffic aimed at channel zero reaches no storage
    p_null_host_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_ch == '0) |-> !en_we && !ent_we);

    // R5: an issued cell always carries the slot's channel
    p_issue_ch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |=> cell_ch == $past(slot_ch));

endmodule

// File: tb/sim_tx_ring_sched.sv
`timescale 1ns/1ps
module sim_tx_ring_sched;
    localparam int CH_W = 3;
    localparam int RING_W = 8;
    localparam int HANDLE_W = 16;
    localparam int NCH = 1 << CH_W;
    localparam int NENT = 1 << RING_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_valid = 1'b0, done_valid = 1'b0, host_we = 1'b0, host_active = 1'b0;
    logic [CH_W-1:0] slot_ch = '0, done_ch = '0, host_ch = '0;
    logic [1:0] host_op = '0;
    logic [RING_W-1:0] host_idx = '0;
    logic [HANDLE_W-1:0] host_handle = '0;
    logic cell_issue, cell_idle;
    logic [CH_W-1:0] cell_ch;
    logic [RING_W-1:0] cell_entry;
    logic [HANDLE_W-1:0] cell_handle;

    always #4 clk = ~clk;

    tx_ring_sched #(.CH_W(CH_W), .RING_W(RING_W), .HANDLE_W(HANDLE_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .slot_valid(slot_valid), .slot_ch(slot_ch),
        .done_valid(done_valid), .done_ch(done_ch),
        .host_we(host_we), .host_op(host_op), .host_ch(host_ch), .host_idx(host_idx),
        .host_active(host_active), .host_handle(host_handle),
        .cell_issue(cell_issue), .cell_idle(cell_idle), .cell_ch(cell_ch),
        .cell_entry(cell_entry), .cell_handle(cell_handle)
    );

    typedef struct packed {
        logic                issue;
        logic [CH_W-1:0]     ch;
        logic [RING_W-1:0]   entry;
        logic [HANDLE_W-1:0] handle;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    int m_head [NCH];
    bit m_en   [NCH];
    bit m_act  [NCH][NENT];
    int m_hdl  [NCH][NENT];

    // Scoreboard monitor: pops one expectation per result strobe
    always @(negedge clk) begin
        if (rst_n && (cell_issue || cell_idle)) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R3 unexpected result issue=%0b idle=%0b ch=%0d, expected none",
                         cell_issue, cell_idle, cell_ch);
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (cell_issue !== e.issue || cell_idle !== !e.issue || cell_ch !== e.ch ||
                    cell_entry !== e.entry || cell_handle !== e.handle) begin
                    n_bad++;
                    $display("FAIL %s actual issue=%0b idle=%0b ch=%0d entry=%0d handle=%h expected issue=%0b ch=%0d entry=%0d handle=%h",
                             t, cell_issue, cell_idle, cell_ch, cell_entry, cell_handle,
                             e.issue, e.ch, e.entry, e.handle);
                end
            end
        end
    end

    // One cycle of stimulus, driven at a falling edge; model updated in design order
    task automatic step(input bit sv, input int sc, input bit dv, input int dc,
                        input bit hw, input int hop, input int hc, input int hi,
                        input bit ha, input int hh, input string tag);
        exp_t e;
        bit   act;
        int   hd;
        bit   host_ent;
        slot_valid = sv; slot_ch = CH_W'(sc);
        done_valid = dv; done_ch = CH_W'(dc);
        host_we = hw; host_op = 2'(hop); host_ch = CH_W'(hc); host_idx = RING_W'(hi);
        host_active = ha; host_handle = HANDLE_W'(hh);
        host_ent = hw && hc != 0 && (hop == 0 || hop == 2);
        if (sv) begin
            e = '0;
            e.ch = CH_W'(sc);
            act = m_act[sc][m_head[sc]];
            hd = m_hdl[sc][m_head[sc]];
            if (host_ent && hc == sc && hi == m_head[sc]) begin
                act = (hop == 0) ? ha : 1'b0;
                if (hop == 0) hd = hh;
            end
            if (sc != 0 && m_en[sc] && act) begin
                e.issue = 1'b1;
                e.entry = RING_W'(m_head[sc]);
                e.handle = HANDLE_W'(hd);
            end
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        if (dv && dc != 0) begin
            m_act[dc][m_head[dc]] = 1'b0;
            m_head[dc] = (m_head[dc] + 1) % NENT;
        end
        if (host_ent) begin
            m_act[hc][hi] = (hop == 0) ? ha : 1'b0;
            if (hop == 0) m_hdl[hc][hi] = hh;
        end
        if (hw && hc != 0 && hop == 1) m_en[hc] = ha;
        @(negedge clk);
        slot_valid = 1'b0; done_valid = 1'b0; host_we = 1'b0;
    endtask

    task automatic slot(input int ch, input string tag);
        step(1, ch, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic done(input int ch);
        step(0, 0, 1, ch, 0, 0, 0, 0, 0, 0, "");
    endtask
    task automatic host(input int op, input int ch, input int idx, input bit a, input int h);
        step(0, 0, 0, 0, 1, op, ch, idx, a, h, "");
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_head[c] = 0; m_en[c] = 1'b0;
            for (int i = 0; i < NENT; i++) begin m_act[c][i] = 1'b0; m_hdl[c][i] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet after reset
        n_chk++;
        if (cell_issue !== 1'b0 || cell_idle !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset outputs issue=%0b idle=%0b expected 0 0", cell_issue, cell_idle);
        end
        // R1: every channel idle after reset
        for (int c = 0; c < NCH; c++) slot(c, "R1");
        // R6: enabled but empty ring gives an idle cell
        host(1, 1, 0, 1, 0);
        slot(1, "R6");
        // R5 / R8: queue four buffers, then serve them in order
        for (int i = 0; i < 4; i++) host(0, 1, i, 1, 16'hA000 + i);
        for (int i = 0; i < 4; i++) begin
            slot(1, "R5");
            slot(1, "R8");
            done(1);
        end
        slot(1, "R6");
        // R4: disabled channel with a queued buffer stays idle
        host(0, 1, 4, 1, 16'hB004);
        host(1, 1, 0, 0, 0);
        slot(1, "R4");
        host(1, 1, 0, 1, 0);
        slot(1, "R4");
        // R2: channel 0 ignores host writes and completions
        host(1, 0, 0, 1, 0);
        host(0, 0, 0, 1, 16'h0BAD);
        done(0);
        slot(0, "R2");
        // R9: same-cycle host write and slot read of the head entry
        host(1, 2, 0, 1, 0);
        step(1, 2, 0, 0, 1, 0, 2, 0, 1, 16'h2222, "R9");
        step(1, 2, 0, 0, 1, 2, 2, 0, 0, 0, "R9");
        slot(2, "R9");
        // R10: retire clears the entry but not the head
        host(0, 2, 0, 1, 16'h2233);
        host(2, 2, 0, 0, 0);
        slot(2, "R10");
        host(0, 2, 0, 1, 16'h2244);
        slot(2, "R10");
        // R11: opcode 3 has no effect
        host(3, 2, 0, 0, 16'hFFFF);
        slot(2, "R11");
        host(3, 4, 0, 1, 0);
        slot(4, "R11");
        // R12 / R7: collision at entry 0 of channel 3, then a full lap
        host(1, 3, 0, 1, 0);
        step(0, 0, 1, 3, 1, 0, 3, 0, 1, 16'h3333, "");
        for (int i = 0; i < 254; i++) done(3);
        host(0, 3, 255, 1, 16'hFF55);
        slot(3, "R7");
        done(3);
        slot(3, "R12");
        slot(3, "R7");
        // R3: quiet cycles after the last slot
        repeat (4) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R3 pending results %0d expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired, actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule